// File: doc/BRIEF.md
# I2C serial EEPROM slave controller

This block is the serial front end of a 1024-byte non-volatile store. The store is modelled here as a register array. The block watches the two I2C bus lines through synchronizers and pulls SDA low through an open-drain enable. It answers to a fixed four-bit device code plus the level on one hardware select pin. Two further bits of the address byte pick a 256-byte quarter of the store, and a word-address byte that follows supplies the low eight bits of the location.

Writes never go to the array directly. Incoming data bytes collect in an eight-entry latch, with the low three address bits stepping and wrapping inside an aligned eight-byte block. A STOP hands the latch to a self-timed erase/write interval. The interval is a prescaler followed by a step counter, and the array is updated when it ends. While the interval runs the slave refuses its own address, so a master can poll until the device answers again. A write-protect pin held high stops any pending data from reaching the array.

Reads either continue from the current pointer or first load it with a write-type address phase followed by a repeated START. The pointer then advances across the whole 10-bit space for as long as the master acknowledges.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The slave acknowledges (drives `sda_oe_o` high during the ninth clock) an address byte, sent MSB first, only if bits 7..4 are 1010, bit 3 equals `sel_i` and no erase/write interval is running. Any other address byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: The memory location is 10 bits wide. Bits 9..8 come from address-byte bits 2..1 and bits 7..0 come from the word-address byte. The same low byte in different quarters names different locations.
- R3: A write with one data byte, closed by STOP, stores that byte at the addressed location once the erase/write interval ends.
- R4: In a multi-byte write, each data byte goes to the latch at the current offset. The offset is the low 3 address bits, and it steps and wraps within the aligned 8-byte block. A ninth or later byte overwrites the entry written 8 bytes before it. All latched bytes are committed together.
- R5: Random read: a write-type address phase, a repeated START and a read address byte (bit 0 = 1) return the byte at the loaded location.
- R6: Sequential read returns successive locations while the master acknowledges. The pointer increments over the full 10-bit range and wraps from 1023 to 0.
- R7: When `wp_i` is high at the STOP of a write, the array stays unchanged, no erase/write interval starts and the slave keeps acknowledging its address.
- R8: The erase/write interval lasts EW_DIV x EW_STEPS clock cycles, 2048 by default, counted from the STOP. During it the slave gives no acknowledge to any address byte.
- R9: A master NACK after a read byte ends the transfer. The slave releases SDA and drives nothing until the next START.
- R10: A START or STOP seen at any bit position resets the bit state machine. A write cut off inside its first data byte commits nothing and starts no interval.
- R11: While `rst_ni` is low and right after reset, `sda_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sel_i | input | 1 | Hardware select level, compared with address bit 3 |
| wp_i | input | 1 | Active-high write protect |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The hardest situation to reach from the ports is the edge of the erase/write window. An address byte has to land a little before the interval ends, and then another a little after. The stimulus issues one poll straight after a STOP, then a second poll timed so that its acknowledge bit falls about a hundred cycles before the 2048-cycle boundary, and then a third poll just after it. Page wrap and overwrite are driven by a ten-byte write that starts at offset 5 of a block. A random mix of addresses and burst lengths, drawn from a fixed seed, is read back against a bench model of the array.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ew_timer.sv
module ew_timer #(
  parameter int DIV   = 128,
  parameter int STEPS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int PRE_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int TOTAL  = DIV * STEPS;
  localparam int LEN_W  = $clog2(TOTAL) + 2;

  logic [PRE_W-1:0]  pre_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, tick;

  assign tick   = busy_q && (pre_q == PRE_W'(DIV - 1));
  assign done_o = tick && (step_q == STEP_W'(STEPS - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      step_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      pre_q  <= '0;
      step_q <= '0;
    end else if (busy_q) begin
      if (tick) begin
        pre_q <= '0;
        if (done_o) busy_q <= 1'b0;
        else        step_q <= step_q + STEP_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  // independent cycle count of the busy window
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (start_i) len_q <= '0;
    else if (busy_q)  len_q <= len_q + LEN_W'(1);
  end

  AST_EW_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> len_q == LEN_W'(TOTAL)); // R8
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R8
endmodule

// File: rtl/page_store.sv
module page_store #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_we_i,
  input  logic              lat_clr_i,
  input  logic              commit_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic              ew_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        rd_data_o,
  output logic              ew_start_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFS_W;

  logic [7:0]            mem_q [DEPTH];
  logic [7:0]            lat_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [BASE_W-1:0]     base_q;

  assign ew_start_o = commit_i && (|mask_q) && !wp_i && !busy_i;
  assign rd_data_o  = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) lat_q[i] <= '0;
    end else if (lat_clr_i) begin
      mask_q <= '0;
    end else if (lat_we_i) begin
      lat_q[addr_i[OFS_W-1:0]]  <= data_i;
      mask_q[addr_i[OFS_W-1:0]] <= 1'b1;
      base_q                    <= addr_i[ADDR_W-1:OFS_W];
    end else if (commit_i && wp_i && !busy_i) begin
      mask_q <= '0; // protected: drop the page
    end else if (ew_done_i) begin
      mask_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ew_done_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_q[i]) mem_q[{base_q, OFS_W'(i)}] <= lat_q[i];
      end
    end
  end

  AST_LATCH_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ew_done_i |=> mask_q == '0); // R4
  AST_NO_FILL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !lat_we_i); // R8
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              sel_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              lat_we_o,
  output logic              lat_clr_o,
  output logic              commit_o,
  output logic [7:0]        lat_data_o
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int OFS_W = $clog2(PAGE_BYTES);

  slv_state_e        state_q;
  logic [2:0]        bit_cnt_q;
  logic              byte_done_q, in_ack_q, rw_q, mack_q, sda_oe_q;
  logic [7:0]        rx_q, tx_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              dev_hit, byte_end, ack_end;

  assign dev_hit    = (rx_q[7:4] == DEV_CODE) && (rx_q[3] == sel_i) && !busy_i;
  assign byte_end   = scl_fall_i && byte_done_q;
  assign ack_end    = scl_fall_i && in_ack_q;
  assign lat_we_o   = byte_end && (state_q == ST_WDATA);
  assign lat_clr_o  = byte_end && (state_q == ST_ADDR);
  assign lat_data_o = rx_q;
  assign commit_o   = stop_i && (state_q == ST_WDATA);
  assign ptr_o      = ptr_q;
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      byte_done_q <= 1'b0;
      in_ack_q    <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      sda_oe_q    <= 1'b0;
      rx_q        <= '0;
      tx_q        <= '0;
      hi_q        <= '0;
      ptr_q       <= '0;
    end else if (start_i || stop_i) begin
      state_q     <= start_i ? ST_DEV : ST_IDLE;
      bit_cnt_q   <= '0;
      byte_done_q <= 1'b0;
      in_ack_q    <= 1'b0;
      sda_oe_q    <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise_i && !in_ack_q) begin
        if (state_q != ST_RDATA) rx_q <= {rx_q[6:0], sda_i};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) byte_done_q <= 1'b1;
      end else if (scl_rise_i && in_ack_q) begin
        mack_q <= !sda_i;
      end

      if (byte_end) begin
        byte_done_q <= 1'b0;
        in_ack_q    <= 1'b1;
        case (state_q)
          ST_DEV: begin
            if (dev_hit) begin
              sda_oe_q <= 1'b1;
              rw_q     <= rx_q[0];
              hi_q     <= rx_q[HI_W:1];
              if (rx_q[0]) ptr_q[ADDR_W-1:8] <= rx_q[HI_W:1];
            end else begin
              state_q  <= ST_IDLE;
              in_ack_q <= 1'b0;
            end
          end
          ST_ADDR: begin
            ptr_q    <= {hi_q, rx_q};
            sda_oe_q <= 1'b1;
          end
          ST_WDATA: begin
            ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + OFS_W'(1);
            sda_oe_q         <= 1'b1;
          end
          ST_RDATA: begin
            ptr_q    <= ptr_q + ADDR_W'(1);
            sda_oe_q <= 1'b0;
          end
          default: ;
        endcase
      end else if (ack_end) begin
        in_ack_q  <= 1'b0;
        bit_cnt_q <= '0;
        case (state_q)
          ST_DEV: begin
            if (rw_q) begin
              state_q  <= ST_RDATA;
              tx_q     <= rd_data_i;
              sda_oe_q <= !rd_data_i[7];
            end else begin
              state_q  <= ST_ADDR;
              sda_oe_q <= 1'b0;
            end
          end
          ST_ADDR: begin
            state_q  <= ST_WDATA;
            sda_oe_q <= 1'b0;
          end
          ST_WDATA: sda_oe_q <= 1'b0;
          ST_RDATA: begin
            if (mack_q) begin
              tx_q     <= rd_data_i;
              sda_oe_q <= !rd_data_i[7];
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end else if (scl_fall_i && state_q == ST_RDATA && !in_ack_q) begin
        tx_q     <= {tx_q[6:0], 1'b0};
        sda_oe_q <= !tx_q[6];
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_DEV && !sda_oe_q && !byte_done_q)); // R10
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !sda_oe_q)); // R10
  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && state_q == ST_DEV && busy_i) |=> !sda_oe_q); // R8
  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_end && state_q == ST_RDATA && !mack_q) |=> (state_q == ST_IDLE && !sda_oe_q)); // R9
  AST_PAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_we_o |=> $stable(ptr_q[ADDR_W-1:OFS_W])); // R4
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 8,
  parameter int EW_DIV      = 128,
  parameter int EW_STEPS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sel_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              ew_start, ew_busy, ew_done;
  logic              lat_we, lat_clr, commit;
  logic [7:0]        lat_data, rd_data;
  logic [ADDR_W-1:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_slave_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .sda_i(sda_s),
    .sel_i, .busy_i(ew_busy), .rd_data_i(rd_data),
    .sda_oe_o, .ptr_o(ptr), .lat_we_o(lat_we), .lat_clr_o(lat_clr),
    .commit_o(commit), .lat_data_o(lat_data)
  );

  page_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk_i, .rst_ni,
    .lat_we_i(lat_we), .lat_clr_i(lat_clr), .commit_i(commit),
    .wp_i, .busy_i(ew_busy), .ew_done_i(ew_done),
    .addr_i(ptr), .data_i(lat_data),
    .rd_data_o(rd_data), .ew_start_o(ew_start)
  );

  ew_timer #(.DIV(EW_DIV), .STEPS(EW_STEPS)) u_timer (
    .clk_i, .rst_ni, .start_i(ew_start), .busy_o(ew_busy), .done_o(ew_done)
  );

  AST_WP_NO_EW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ew_busy) |-> !$past(wp_i)); // R7
endmodule

// File: tb/eeprom_i2c_slave_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb;
  localparam int H = 20;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_pull = 1'b0, sel = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = !(m_pull || sda_oe);

  always #2.5 clk = ~clk;

  eeprom_i2c_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sel_i(sel), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_mem [1024];
  bit         known [1024];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input int addr, input bit rd, input bit hs);
    logic [9:0] a = addr[9:0];
    return {4'b1010, hs, a[9:8], rd};
  endfunction

  function automatic int slot_addr(input int base, input int i);
    return (base & ~7) | ((base + i) & 7);
  endfunction

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic start_c();
    m_pull = 0; wt(Q); scl = 1; wt(H); m_pull = 1; wt(H); scl = 0;
  endtask

  task automatic stop_c();
    wt(Q); m_pull = 1; wt(Q); scl = 1; wt(H); m_pull = 0; wt(H);
  endtask

  task automatic send_bit(input bit b);
    wt(Q); m_pull = !b; wt(Q); scl = 1; wt(H); scl = 0;
  endtask

  task automatic get_bit(output bit b);
    wt(Q); m_pull = 0; wt(Q); scl = 1; wt(Q); b = sda_line; wt(Q); scl = 0;
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] b);
    bit x;
    for (int i = 0; i < 8; i++) begin get_bit(x); b = {b[6:0], x}; end
    send_bit(!ack);
  endtask

  task automatic write_seq(input int addr, input int n, output bit ok);
    bit a;
    start_c();
    write_byte(dev_byte(addr, 0, 1), ok);
    if (ok) begin
      write_byte(8'(addr), a);
      for (int i = 0; i < n; i++) write_byte(wbuf[i], a);
    end
    stop_c();
    if (ok && !wp) begin
      for (int i = 0; i < n; i++) begin
        exp_mem[slot_addr(addr, i)] = wbuf[i];
        known[slot_addr(addr, i)]   = 1;
      end
    end
  endtask

  task automatic read_seq(input int addr, input int n, output bit ok);
    bit a;
    start_c();
    write_byte(dev_byte(addr, 0, 1), ok);
    write_byte(8'(addr), a);
    start_c();
    write_byte(dev_byte(addr, 1, 1), a);
    ok = ok && a;
    for (int i = 0; i < n; i++) read_byte(i != n - 1, rbuf[i]);
    stop_c();
  endtask

  task automatic poll(output bit ack);
    start_c();
    write_byte(dev_byte(0, 0, 1), ack);
    stop_c();
  endtask

  task automatic wait_ready();
    bit a;
    for (int t = 0; t < 40; t++) begin
      poll(a);
      if (a) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok, a, x;
    logic [7:0] b;
    int unsigned seed;
    for (int i = 0; i < 1024; i++) begin known[i] = 0; exp_mem[i] = 0; end
    seed = $urandom(32'd7351);

    wt(5);
    chk("R11 in reset", sda_oe, 0);
    rst_n = 1;
    wt(10);
    chk("R11 after reset", sda_oe, 0);

    // R1: wrong device code, wrong select bit, correct address
    start_c(); write_byte(8'b1011_1000, a); stop_c();
    chk("R1 bad code", a, 0);
    start_c(); write_byte(dev_byte(0, 0, 0), a); stop_c();
    chk("R1 bad select", a, 0);
    poll(a);
    chk("R1 match", a, 1);

    // R3 / R8: byte write, then polls around the end of the interval
    wbuf[0] = 8'h5A;
    write_seq(10'h2C7, 1, ok);
    chk("R1 write addr ack", ok, 1);
    poll(a);
    chk("R8 busy right after stop", a, 0);
    wt(1100);
    poll(a);
    chk("R8 busy near end of window", a, 0);
    wt(200);
    poll(a);
    chk("R8 ready after window", a, 1);
    read_seq(10'h2C7, 1, ok);
    chk("R5 random read ack", ok, 1);
    chk("R3 byte stored", rbuf[0], 8'h5A);

    // R2: same low byte, different quarter
    wbuf[0] = 8'hA5;
    write_seq(10'h0C7, 1, ok);
    wait_ready();
    read_seq(10'h0C7, 1, ok);
    chk("R2 quarter 0", rbuf[0], 8'hA5);
    read_seq(10'h2C7, 1, ok);
    chk("R2 quarter 2 untouched", rbuf[0], 8'h5A);

    // R4: ten bytes from offset 5, wrap and overwrite
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h30 + i * 7);
    write_seq(10'h135, 10, ok);
    wait_ready();
    read_seq(10'h130, 8, ok);
    for (int i = 0; i < 8; i++) chk("R4 page wrap", rbuf[i], exp_mem[10'h130 + i]);
    chk("R4 overwrite slot 5", rbuf[5], 8'h30 + 8 * 7);

    // R6: sequential read across 1023 -> 0
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hC0 + i);
    write_seq(10'h3FC, 4, ok);
    wait_ready();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_seq(10'h000, 2, ok);
    wait_ready();
    read_seq(10'h3FE, 4, ok);
    chk("R6 seq 3FE", rbuf[0], 8'hC2);
    chk("R6 seq 3FF", rbuf[1], 8'hC3);
    chk("R6 seq wrap 000", rbuf[2], 8'h11);
    chk("R6 seq 001", rbuf[3], 8'h22);

    // R9: master NACK ends the read
    start_c();
    write_byte(dev_byte(10'h2C7, 0, 1), a);
    write_byte(8'hC7, a);
    start_c();
    write_byte(dev_byte(10'h2C7, 1, 1), a);
    read_byte(0, b);
    chk("R9 data before nack", b, 8'h5A);
    wt(5);
    chk("R9 released after nack", sda_oe, 0);
    get_bit(x);
    chk("R9 silent after nack", x, 1);
    stop_c();

    // R7: write protect
    wp = 1;
    wbuf[0] = 8'hEE;
    write_seq(10'h2C7, 1, ok);
    poll(a);
    chk("R7 no interval started", a, 1);
    wp = 0;
    read_seq(10'h2C7, 1, ok);
    chk("R7 array unchanged", rbuf[0], 8'h5A);

    // R10: STOP inside first data byte
    start_c();
    write_byte(dev_byte(10'h2C7, 0, 1), a);
    write_byte(8'hC7, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    stop_c();
    poll(a);
    chk("R10 stop mid byte no interval", a, 1);
    read_seq(10'h2C7, 1, ok);
    chk("R10 stop mid byte no write", rbuf[0], 8'h5A);

    // R10: START inside a byte restarts the frame
    start_c();
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    start_c();
    write_byte(dev_byte(10'h0C7, 0, 1), a);
    chk("R10 restart addr ack", a, 1);
    write_byte(8'hC7, a);
    start_c();
    write_byte(dev_byte(10'h0C7, 1, 1), a);
    read_byte(0, b);
    stop_c();
    chk("R10 restart read", b, 8'hA5);

    // random writes and read-back (R3, R4)
    for (int k = 0; k < 6; k++) begin
      int addr, n;
      addr = int'($urandom % 1024);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_seq(addr, n, ok);
      wait_ready();
      read_seq(addr & ~7, 8, ok);
      for (int i = 0; i < 8; i++)
        if (known[(addr & ~7) + i]) chk("R3 R4 random readback", rbuf[i], exp_mem[(addr & ~7) + i]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule